// File: doc/BRIEF.md
# Two-Level Clear-on-Read Interrupt Controller

This block collects a large number of single-bit event lines into one interrupt output. Each event line belongs to a 16-bit second-level status register. A rising edge on the line sets the matching status bit, and that bit stays set until software reads the register. The read returns the bits and clears them in the same access. Each status register has its own mask register. The unmasked pending bits are grouped by source family. Each family drives one bit of a top-level summary register, and a top-level mask register can block any family as a whole.

Software reaches all registers through a simple synchronous register port. A read returns its data one clock after the request. The interrupt output is registered and level-sensitive, and a control bit sets its active level. Software first masks everything by writing all ones to every mask. It then clears the sub-masks it wants to use and writes zero to the top-level mask. While it services an interrupt, any new event sets a bit again and keeps the output active, so no event is lost.

Top module: `irqc_top`

## Requirements
- R1: After reset, every sub-mask register and the top-level mask read 0xFFFF, all status registers, the summary and the control register read 0, and `irq_o` is high, which is the inactive level for active-low.
- R2: A 0-to-1 transition on a source input sets its status bit at the next clock. The bit is sticky, and a level that stays high does not set it again after a clear.
- R3: A read of a status register (address 0x10 + n, n = 0..6) returns its bits on `rdata_o` one cycle after the request, and clears the register.
- R4: When a source edge and a read of its status register fall in the same cycle, the read returns the old value and the new bit stays set.
- R5: A sub-mask bit of 1 (address 0x18 + n) keeps its status bit out of the summary. The status bit is still latched and can be read.
- R6: Summary bit g (address 0x00, read-only) is the OR of the unmasked pending bits of group g. Groups are: sub 0 bits 7:0 → 0 and bits 15:8 → 1; sub 1 bits 7:0 → 2 and bits 15:8 → 3; subs 2, 3, 4 and 5 → 4, 5, 6 and 7; sub 6 bits 5:0 → 8, bits 11:6 → 9 and bits 15:12 → 10. Summary bits 15:11 read 0.
- R7: A top-level mask bit of 1 (address 0x01) stops its summary bit from driving `irq_o`. The summary register still shows that bit.
- R8: Sub-mask bits 15:12 of sub 2 and bits 15:13 of sub 5 are fixed. They always read 1, and writes to them have no effect.
- R9: Control bit 0 (address 0x02) selects the polarity, 1 for active-high and 0 for active-low. `irq_o` shows the active level one cycle after any unmasked summary bit is set.
- R10: If a new event arrives after a status read has cleared the earlier events, `irq_o` becomes active again.
- R11: Reads of unmapped addresses return 0. Writes to the summary and status addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_i | input | NSUB*DW | Event lines; line b of sub-register n is at bit n*DW+b |
| rd_en_i | input | 1 | Register read request |
| wr_en_i | input | 1 | Register write request |
| addr_i | input | AW | Register address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, valid the cycle after the request |
| irq_o | output | 1 | Interrupt output, polarity set by the control register |

## Verification
The hardest case to reach from the ports is a source edge that lands in the same clock as the read that clears its register. The read must return the older contents, and the new bit must stay pending. The bench drives the rising line and the read request at the same falling edge, so both take effect at one rising edge. It then reads the register again to show the bit that survived. A second hard case is a status bit that is latched but masked. The stimulus holds a sub-mask closed while an event arrives and checks that `irq_o` stays idle. It then opens the mask and shows that the interrupt follows.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int REG_W = 16;
  localparam int SUB_N = 7;
  localparam int GRP_N = 16;

  localparam int A_SUMMARY = 'h00;
  localparam int A_TOPMASK = 'h01;
  localparam int A_CTRL    = 'h02;
  localparam int A_STAT0   = 'h10;
  localparam int A_MASK0   = 'h18;

  // Family (summary bit) that a given status bit rolls up into.
  function automatic int grp_of(int sub, int bitn);
    case (sub)
      0:       return (bitn < 8) ? 0 : 1;
      1:       return (bitn < 8) ? 2 : 3;
      2:       return 4;
      3:       return 5;
      4:       return 6;
      5:       return 7;
      default: return (bitn < 6) ? 8 : ((bitn < 12) ? 9 : 10);
    endcase
  endfunction

  // Mask positions that hardware holds at 1.
  function automatic logic [REG_W-1:0] fixed_mask(int sub);
    case (sub)
      2:       return 16'hF000;
      5:       return 16'hE000;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/irqc_sub.sv
module irqc_sub #(
  parameter int DW = 16,
  parameter logic [DW-1:0] FIXED = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] src_i,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] edge_o,
  output logic [DW-1:0] stat_o,
  output logic [DW-1:0] mask_o,
  output logic [DW-1:0] pend_o
);
  logic [DW-1:0] prev_q, stat_q, mask_q;

  assign edge_o = src_i & ~prev_q;
  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign pend_o = stat_q & ~mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      stat_q <= '0;
      mask_q <= '1;
    end else begin
      prev_q <= src_i;
      // a fresh edge overrides the read-clear
      stat_q <= (clr_i ? '0 : stat_q) | edge_o;
      if (wr_i) mask_q <= wdata_i | FIXED;
    end
  end
endmodule

// File: rtl/irqc_rollup.sv
module irqc_rollup #(
  parameter int DW   = 16,
  parameter int NSUB = 7,
  parameter int NGRP = 16
) (
  input  logic [NSUB-1:0][DW-1:0] pend_i,
  output logic [NGRP-1:0]         sum_o
);
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    always_comb begin
      sum_o[g] = 1'b0;
      for (int s = 0; s < NSUB; s++) begin
        for (int b = 0; b < DW; b++) begin
          if (irqc_pkg::grp_of(s, b) == g) sum_o[g] = sum_o[g] | pend_i[s][b];
        end
      end
    end
  end
endmodule

// File: rtl/irqc_out.sv
module irqc_out (
  input  logic clk,
  input  logic rst,
  input  logic any_i,
  input  logic pol_i,
  output logic irq_o
);
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b1;
    else     irq_o <= pol_i ? any_i : ~any_i;
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int DW   = irqc_pkg::REG_W,
  parameter int NSUB = irqc_pkg::SUB_N,
  parameter int NGRP = irqc_pkg::GRP_N,
  parameter int AW   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NSUB*DW-1:0] src_i,
  input  logic               rd_en_i,
  input  logic               wr_en_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  output logic               irq_o
);
  localparam logic [AW-1:0] ADR_SUM  = AW'(irqc_pkg::A_SUMMARY);
  localparam logic [AW-1:0] ADR_TOPM = AW'(irqc_pkg::A_TOPMASK);
  localparam logic [AW-1:0] ADR_CTRL = AW'(irqc_pkg::A_CTRL);

  logic [NSUB-1:0][DW-1:0] edge_w, stat_w, mask_w, pend_w;
  logic [NGRP-1:0]         summary;
  logic [NGRP-1:0]         topmask_q;
  logic                    pol_q;
  logic                    any_pend;
  logic [DW-1:0]           rd_mux;

  for (genvar s = 0; s < NSUB; s++) begin : g_sub
    localparam logic [AW-1:0] ADR_ST = AW'(irqc_pkg::A_STAT0 + s);
    localparam logic [AW-1:0] ADR_MK = AW'(irqc_pkg::A_MASK0 + s);
    irqc_sub #(
      .DW   (DW),
      .FIXED(DW'(irqc_pkg::fixed_mask(s)))
    ) u_sub (
      .clk    (clk),
      .rst    (rst),
      .src_i  (src_i[s*DW +: DW]),
      .clr_i  (rd_en_i && addr_i == ADR_ST),
      .wr_i   (wr_en_i && addr_i == ADR_MK),
      .wdata_i(wdata_i),
      .edge_o (edge_w[s]),
      .stat_o (stat_w[s]),
      .mask_o (mask_w[s]),
      .pend_o (pend_w[s])
    );
  end

  irqc_rollup #(.DW(DW), .NSUB(NSUB), .NGRP(NGRP)) u_rollup (
    .pend_i(pend_w),
    .sum_o (summary)
  );

  assign any_pend = |(summary & ~topmask_q);

  irqc_out u_out (
    .clk  (clk),
    .rst  (rst),
    .any_i(any_pend),
    .pol_i(pol_q),
    .irq_o(irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      topmask_q <= '1;
      pol_q     <= 1'b0;
    end else if (wr_en_i) begin
      if (addr_i == ADR_TOPM) topmask_q <= NGRP'(wdata_i);
      if (addr_i == ADR_CTRL) pol_q     <= wdata_i[0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i == ADR_SUM)  rd_mux = DW'(summary);
    if (addr_i == ADR_TOPM) rd_mux = DW'(topmask_q);
    if (addr_i == ADR_CTRL) rd_mux = DW'(pol_q);
    for (int s = 0; s < NSUB; s++) begin
      if (addr_i == AW'(irqc_pkg::A_STAT0 + s)) rd_mux = stat_w[s];
      if (addr_i == AW'(irqc_pkg::A_MASK0 + s)) rd_mux = mask_w[s];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int DW   = 16,
  parameter int NSUB = 7,
  parameter int AW   = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               rd_en,
  input logic [AW-1:0]      addr,
  input logic [DW-1:0]      rdata,
  input logic               irq,
  input logic               pol,
  input logic               any_pend,
  input logic [NSUB*DW-1:0] stat_all,
  input logic [NSUB*DW-1:0] edge_all
);
  // R2: a status bit falls only after a status-register read
  a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
    (|($past(stat_all) & ~stat_all)) |->
      ($past(rd_en) && $past(addr) >= AW'(irqc_pkg::A_STAT0) &&
       $past(addr) < AW'(irqc_pkg::A_STAT0 + NSUB)));

  // R4: every detected edge is held in the next cycle, read or not
  a_r4_set_wins: assert property (@(posedge clk) disable iff (rst)
    (|edge_all) |=> ((stat_all & $past(edge_all)) == $past(edge_all)));

  for (genvar s = 0; s < NSUB; s++) begin : g_chk
    // R3: after a read only the bits that arrived during it remain
    a_r3_read_clears: assert property (@(posedge clk) disable iff (rst)
      (rd_en && addr == AW'(irqc_pkg::A_STAT0 + s)) |=>
        ((stat_all[s*DW +: DW] & ~$past(edge_all[s*DW +: DW])) == '0));
    if (irqc_pkg::fixed_mask(s) != 0) begin : g_fix
      // R8: fixed mask positions read back as 1
      a_r8_fixed_bits: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == AW'(irqc_pkg::A_MASK0 + s)) |=>
          ((rdata & DW'(irqc_pkg::fixed_mask(s))) == DW'(irqc_pkg::fixed_mask(s))));
    end
  end

  // R9: output level follows pending state with the chosen polarity
  a_r9_active_high: assert property (@(posedge clk) disable iff (rst)
    $past(pol) |-> (irq == $past(any_pend)));
  a_r9_active_low: assert property (@(posedge clk) disable iff (rst)
    !$past(pol) |-> (irq == !$past(any_pend)));
endmodule

bind irqc_top irqc_chk #(.DW(DW), .NSUB(NSUB), .AW(AW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .rd_en   (rd_en_i),
  .addr    (addr_i),
  .rdata   (rdata_o),
  .irq     (irq_o),
  .pol     (pol_q),
  .any_pend(any_pend),
  .stat_all(stat_w),
  .edge_all(edge_w)
);

// File: tb/irqc_top_tb.sv
`timescale 1ns/100ps
module irqc_top_tb;
  localparam int DW = 16;
  localparam int NS = 7;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NS*DW-1:0] src = '0;
  logic           rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0]     addr = '0;
  logic [15:0]    wdata = '0;
  logic [15:0]    rdata;
  logic           irq;

  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  irqc_top u_dut (
    .clk(clk), .rst(rst), .src_i(src), .rd_en_i(rd_en), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // ---------------- reference model ----------------
  logic [15:0] m_prev [NS];
  logic [15:0] m_stat [NS];
  logic [15:0] m_mask [NS];
  logic [15:0] m_top;
  logic        m_pol;
  logic [15:0] e_rdata;
  logic        e_irq;
  string       rd_tag = "R1";

  function automatic logic [15:0] m_fix(int s);
    if (s == 2) return 16'hF000;
    if (s == 5) return 16'hE000;
    return 16'h0000;
  endfunction

  function automatic int m_grp(int s, int b);
    int g;
    if (s == 6) g = 8 + b / 6;
    else if (s >= 2) g = s + 2;
    else g = 2 * s + b / 8;
    return g;
  endfunction

  function automatic logic [15:0] m_summary();
    logic [15:0] r = '0;
    for (int s = 0; s < NS; s++)
      for (int b = 0; b < 16; b++)
        if (m_stat[s][b] && !m_mask[s][b]) r[m_grp(s, b)] = 1'b1;
    return r;
  endfunction

  function automatic logic [15:0] m_read(logic [7:0] a);
    if (a == 8'h00) return m_summary();
    if (a == 8'h01) return m_top;
    if (a == 8'h02) return {15'd0, m_pol};
    if (a >= 8'h10 && a < 8'h17) return m_stat[a - 8'h10];
    if (a >= 8'h18 && a < 8'h1F) return m_mask[a - 8'h18];
    return 16'h0000;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NS; s++) begin
        m_prev[s] = '0; m_stat[s] = '0; m_mask[s] = 16'hFFFF;
      end
      m_top = 16'hFFFF; m_pol = 1'b0; e_rdata = '0; e_irq = 1'b1;
    end else begin
      logic any;
      any = |(m_summary() & ~m_top);
      e_irq = m_pol ? any : !any;
      if (rd_en) begin
        e_rdata = m_read(addr);
        if (addr == 8'h00) rd_tag = "R6";
        else if (addr == 8'h01) rd_tag = "R7";
        else if (addr == 8'h02) rd_tag = "R9";
        else if (addr >= 8'h10 && addr < 8'h17) rd_tag = "R3";
        else if (addr >= 8'h18 && addr < 8'h1F) rd_tag = "R8";
        else rd_tag = "R11";
      end
      for (int s = 0; s < NS; s++) begin
        logic [15:0] ed;
        ed = src[s*DW +: DW] & ~m_prev[s];
        m_prev[s] = src[s*DW +: DW];
        if (rd_en && addr == 8'(8'h10 + s)) m_stat[s] = '0;
        m_stat[s] = m_stat[s] | ed;
        if (wr_en && addr == 8'(8'h18 + s)) m_mask[s] = wdata | m_fix(s);
      end
      if (wr_en && addr == 8'h01) m_top = wdata;
      if (wr_en && addr == 8'h02) m_pol = wdata[0];
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      tests++;
      if (rdata !== e_rdata) begin
        fails++;
        $display("FAIL %s model rdata act=%h exp=%h", rd_tag, rdata, e_rdata);
      end
      tests++;
      if (irq !== e_irq) begin
        fails++;
        $display("FAIL R9 model irq act=%b exp=%b", irq, e_irq);
      end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [15:0] exp, string tag);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    chk(tag, rdata, exp);
  endtask

  task automatic pulse(int s, int b);
    @(negedge clk); src[s*DW+b] = 1'b1;
    @(negedge clk); src[s*DW+b] = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", {15'd0, irq}, 16'h0001);
    rd(8'h18, 16'hFFFF, "R1");
    rd(8'h01, 16'hFFFF, "R1");
    rd(8'h10, 16'h0000, "R1");
    rd(8'h02, 16'h0000, "R1");

    wr(8'h02, 16'h0001);
    wr(8'h01, 16'h0000);
    wr(8'h18, 16'h0000);

    // R2 latch on edge
    pulse(0, 3); idle(1);
    chk("R2", {15'd0, irq}, 16'h0001);
    rd(8'h00, 16'h0001, "R6");
    // R3 clear on read
    rd(8'h10, 16'h0008, "R3");
    rd(8'h10, 16'h0000, "R3");
    idle(1);
    chk("R3", {15'd0, irq}, 16'h0000);

    // R2 held level does not re-set
    @(negedge clk); src[0*DW+5] = 1'b1;
    idle(2);
    rd(8'h10, 16'h0020, "R2");
    idle(2);
    rd(8'h10, 16'h0000, "R2");
    @(negedge clk); src[0*DW+5] = 1'b0;

    // R4 set wins over read clear
    pulse(0, 1);
    @(negedge clk); src[0*DW+9] = 1'b1; rd_en = 1'b1; addr = 8'h10;
    @(negedge clk); rd_en = 1'b0; src[0*DW+9] = 1'b0;
    chk("R4", rdata, 16'h0002);
    rd(8'h10, 16'h0200, "R4");

    // R5 sub-mask blocks but status still latches
    pulse(1, 2); idle(2);
    chk("R5", {15'd0, irq}, 16'h0000);
    rd(8'h00, 16'h0000, "R5");
    wr(8'h19, 16'h0000); idle(1);
    chk("R5", {15'd0, irq}, 16'h0001);

    // R7 top mask
    wr(8'h01, 16'h0004); idle(1);
    chk("R7", {15'd0, irq}, 16'h0000);
    rd(8'h00, 16'h0004, "R7");
    wr(8'h01, 16'h0000);
    rd(8'h11, 16'h0004, "R3");

    // R6 groups sharing sub 6
    wr(8'h1E, 16'h0000);
    @(negedge clk); src[6*DW+0] = 1'b1; src[6*DW+7] = 1'b1; src[6*DW+13] = 1'b1;
    @(negedge clk); src[6*DW +: DW] = '0;
    rd(8'h00, 16'h0700, "R6");
    pulse(1, 12);
    rd(8'h00, 16'h0708, "R6");
    rd(8'h16, 16'h2081, "R6");
    rd(8'h11, 16'h1000, "R6");

    // R8 fixed mask bits
    wr(8'h1A, 16'h0000);
    rd(8'h1A, 16'hF000, "R8");
    wr(8'h1D, 16'h0001);
    rd(8'h1D, 16'hE001, "R8");
    pulse(2, 14); idle(2);
    chk("R8", {15'd0, irq}, 16'h0000);
    rd(8'h12, 16'h4000, "R8");

    // R9 active-low polarity
    wr(8'h02, 16'h0000); idle(1);
    chk("R9", {15'd0, irq}, 16'h0001);
    pulse(3, 0); wr(8'h1B, 16'h0000); idle(1);
    chk("R9", {15'd0, irq}, 16'h0000);

    // R10 re-assertion after service
    rd(8'h13, 16'h0001, "R10");
    idle(1);
    chk("R10", {15'd0, irq}, 16'h0001);
    pulse(3, 4); idle(1);
    chk("R10", {15'd0, irq}, 16'h0000);
    rd(8'h13, 16'h0010, "R10");

    // R11 address map
    rd(8'h05, 16'h0000, "R11");
    rd(8'h1F, 16'h0000, "R11");
    wr(8'h00, 16'hFFFF);
    wr(8'h14, 16'hFFFF);
    rd(8'h14, 16'h0000, "R11");
    rd(8'h00, 16'h0000, "R11");

    idle(4);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule